// File: doc/BRIEF.md
# Infrared Run-Length Receiver

This block takes the demodulated level from an infrared receiver, samples it at a slow rate and stores what it sees as a sequence of run-length bytes in a receive FIFO. Each byte holds one level (pulse or space) and how many samples that level lasted. A host reads the bytes through a pop strobe and a show-ahead data port. A status word reports overflow, packet end, data-available and the FIFO fill count, and a single interrupt line follows the enabled status bits.

The sample tick is the block clock divided by one of two parameterised ratios. Before run-length encoding, the sampled level can be inverted and passes through a glitch filter. A packet opens only after the active level has lasted a programmable number of samples. It closes after a programmable stretch of unbroken space, and at that point packet-end status is raised. Between packets nothing is recorded. The protocol meaning of the runs is left to the host.

Top module: `cir_rle_rx`

## Requirements
- R1: No entry enters the FIFO unless both `en_global` and `en_rx` are 1. While either is 0, the sampling, filter and packet logic are held in their idle state.
- R2: `samp_cfg[0]` selects the sample tick period: 0 gives `FAST_DIV` clock cycles per sample and 1 gives `SLOW_DIV` clock cycles per sample.
- R3: When `rx_invert` is 1, the input is inverted before sampling. After this step, a sampled level of 1 is the active (pulse) level and 0 is space.
- R4: The filter length F is `samp_cfg[7:2]`. A change of level that lasts fewer than F consecutive samples is ignored, and those samples count toward the surrounding run. Runs of at least F samples keep their exact length.
- R5: A packet opens on the sample at which the active level has lasted T = (`samp_cfg[22:16]`+1) samples, or T = 128 times that value when `samp_cfg[23]` is 1. Those T samples are not recorded, so the first pulse entry covers only the active samples that follow.
- R6: Entry format: bit 7 is the level (1 pulse, 0 space) and bits 6:0 are the run length in samples minus one. A run longer than 128 samples is split into entries of duration 127 followed by one entry for the remainder. If the remainder is zero, no entry is written for it.
- R7: With I = `samp_cfg[15:8]`, a packet closes after (I+1)*128 consecutive space samples. This space is recorded as I+1 entries of value 0x7F, packet-end (status bit 1) is set, and later space is not recorded.
- R8: The FIFO returns entries in the order they were written. `fifo_data` shows the oldest entry, `fifo_pop` removes it, and the fill count appears in `status[8 +: CNT_W]`.
- R9: An entry produced while the FIFO holds `DEPTH` entries is dropped and sets the overflow flag (status bit 0). The stored entries are not changed.
- R10: Data-available (status bit 4) is set in every cycle in which the fill count is greater than the level `int_cfg[8 +: CNT_W]`. Once set, it stays set until it is cleared.
- R11: A cycle with `clr_we` high clears each of status bits 0, 1 and 4 whose `clr_bits` bit is 1. A set condition in the same cycle takes priority over the clear.
- R12: `irq` is the OR of status bits 0, 1 and 4, each ANDed with the matching bit of `int_cfg`.
- R13: After reset, the status word is 0, the FIFO is empty and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the base clock of the sample prescaler |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated infrared level (asynchronous) |
| en_global | input | 1 | Global enable |
| en_rx | input | 1 | Receive enable |
| rx_invert | input | 1 | Invert the input before sampling |
| samp_cfg | input | 24 | Sample config: [0] rate select, [7:2] filter length, [15:8] idle count, [22:16] start threshold minus one, [23] start unit x128 |
| int_cfg | input | STS_W | Interrupt enables in bits 0, 1, 4; data-available level in bits 8 and up |
| clr_we | input | 1 | Status clear strobe |
| clr_bits | input | 8 | Write-one-to-clear mask for status bits 0, 1, 4 |
| fifo_pop | input | 1 | Remove the oldest FIFO entry |
| fifo_data | output | 8 | Oldest FIFO entry (show-ahead) |
| status | output | STS_W | Bit 0 overflow, bit 1 packet end, bit 4 data available, fill count from bit 8 |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks several properties on every cycle: the fill count never exceeds the depth, the overflow and packet-end flags hold until a clear is written, data-available follows a fill count above the level, no entry is added while the receiver is disabled, and `irq` stays low with all enables off. The bench must show the run-length content itself: exact byte values under both sample rates, with and without inversion, glitch absorption, the start threshold in both units across a sweep of values, run splitting, the idle close at two idle settings, and which entries survive an overflow. Write-one-to-clear priority and interrupt masking are also exercised by the bench's scenarios, at the ports.

// File: rtl/cir_rle_pkg.sv
package cir_rle_pkg;

    localparam int RUN_CHUNK = 128;
    localparam int DUR_W     = 7;

    typedef struct packed {
        logic             active;
        logic [DUR_W-1:0] dur;
    } run_entry_t;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_PKT  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic       coarse;
        logic [6:0] start_m1;
        logic [7:0] idle_n;
        logic [5:0] min_len;
        logic       slow;
    } samp_cfg_t;

    function automatic samp_cfg_t unpack_cfg(input logic [23:0] w);
        samp_cfg_t c;
        c.slow     = w[0];
        c.min_len  = w[7:2];
        c.idle_n   = w[15:8];
        c.start_m1 = w[22:16];
        c.coarse   = w[23];
        return c;
    endfunction

    // Samples needed before a packet opens.
    function automatic logic [15:0] start_samples(input logic [6:0] m1, input logic coarse);
        logic [15:0] base;
        base = {9'd0, m1} + 16'd1;
        return coarse ? (base << 7) : base;
    endfunction

    // Space samples that close a packet.
    function automatic logic [15:0] idle_samples(input logic [7:0] n);
        return ({8'd0, n} + 16'd1) << 7;
    endfunction

endpackage

// File: rtl/cir_sampler.sv
module cir_sampler #(
    parameter int FAST_DIV = 64,
    parameter int SLOW_DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic slow_sel,
    input  logic invert,
    input  logic ir_raw,
    output logic tick,
    output logic level
);
    localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int PS_W    = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
    localparam logic [PS_W-1:0] FAST_LIM = PS_W'(FAST_DIV - 1);
    localparam logic [PS_W-1:0] SLOW_LIM = PS_W'(SLOW_DIV - 1);

    logic [1:0]      sync_q;
    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] lim;
    logic            wrap;

    always_comb begin
        lim  = slow_sel ? SLOW_LIM : FAST_LIM;
        wrap = (ps_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b00;
            ps_q   <= '0;
        end else begin
            sync_q <= {sync_q[0], ir_raw};
            if (!enable || wrap) ps_q <= '0;
            else                 ps_q <= ps_q + 1'b1;
        end
    end

    assign tick  = enable && wrap;
    assign level = sync_q[1] ^ invert;

endmodule

// File: rtl/cir_glitch_filter.sv
module cir_glitch_filter (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick_in,
    input  logic       level_in,
    input  logic [5:0] min_len,
    output logic       tick_out,
    output logic       level_out
);
    logic [5:0] pend_q;
    logic       lvl_q;
    logic       tick_q;
    logic [6:0] pend_inc;

    assign pend_inc = {1'b0, pend_q} + 7'd1;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pend_q <= '0;
            lvl_q  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_in;
            if (tick_in) begin
                if (level_in == lvl_q) begin
                    pend_q <= '0;
                end else if (pend_inc >= {1'b0, min_len}) begin
                    lvl_q  <= level_in;
                    pend_q <= '0;
                end else begin
                    pend_q <= pend_inc[5:0];
                end
            end
        end
    end

    assign tick_out  = tick_q;
    assign level_out = lvl_q;

endmodule

// File: rtl/cir_run_encoder.sv
module cir_run_encoder
    import cir_rle_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        tick,
    input  logic        level,
    input  logic [15:0] start_len,
    input  logic [15:0] idle_len,
    output logic        push,
    output run_entry_t  entry,
    output logic        pkt_end
);
    rx_state_e   st_q;
    logic [15:0] act_q;
    logic [15:0] idle_q;
    logic        run_lvl_q;
    logic [7:0]  run_q;
    logic [7:0]  run_inc;
    logic [15:0] act_inc;
    logic [15:0] idle_inc;

    always_comb begin
        run_inc  = run_q + 8'd1;
        act_inc  = act_q + 16'd1;
        idle_inc = idle_q + 16'd1;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st_q      <= ST_WAIT;
            act_q     <= '0;
            idle_q    <= '0;
            run_lvl_q <= 1'b0;
            run_q     <= '0;
            push      <= 1'b0;
            entry     <= '0;
            pkt_end   <= 1'b0;
        end else begin
            push    <= 1'b0;
            pkt_end <= 1'b0;
            if (tick) begin
                unique case (st_q)
                    ST_WAIT: begin
                        if (!level) begin
                            act_q <= '0;
                        end else if (act_inc >= start_len) begin
                            st_q      <= ST_PKT;
                            act_q     <= '0;
                            idle_q    <= '0;
                            run_lvl_q <= 1'b1;
                            run_q     <= '0;
                        end else begin
                            act_q <= act_inc;
                        end
                    end
                    ST_PKT: begin
                        if (level == run_lvl_q) begin
                            if (run_inc == 8'(RUN_CHUNK)) begin
                                push  <= 1'b1;
                                entry <= run_entry_t'{active: run_lvl_q, dur: 7'd127};
                                run_q <= '0;
                            end else begin
                                run_q <= run_inc;
                            end
                        end else begin
                            if (run_q != 8'd0) begin
                                push  <= 1'b1;
                                entry <= run_entry_t'{active: run_lvl_q, dur: run_q[6:0] - 7'd1};
                            end
                            run_lvl_q <= level;
                            run_q     <= 8'd1;
                        end
                        // Idle length is a multiple of the chunk, so the
                        // closing sample always coincides with a full chunk.
                        if (level) begin
                            idle_q <= '0;
                        end else if (idle_inc >= idle_len) begin
                            st_q    <= ST_WAIT;
                            pkt_end <= 1'b1;
                            idle_q  <= '0;
                        end else begin
                            idle_q <= idle_inc;
                        end
                    end
                    default: st_q <= ST_WAIT;
                endcase
            end
        end
    end

endmodule

// File: rtl/cir_rx_fifo.sv
module cir_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full
);
    // DEPTH is a power of two, so the pointers wrap naturally.
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    always_comb begin
        full    = (cnt_q == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout  = mem[rd_q];
    assign count = cnt_q;

endmodule

// File: rtl/cir_rle_rx.sv
module cir_rle_rx
    import cir_rle_pkg::*;
#(
    parameter int  DEPTH    = 64,
    parameter int  FAST_DIV = 64,
    parameter int  SLOW_DIV = 128,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int STS_W    = 8 + CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ir_in,
    input  logic             en_global,
    input  logic             en_rx,
    input  logic             rx_invert,
    input  logic [23:0]      samp_cfg,
    input  logic [STS_W-1:0] int_cfg,
    input  logic             clr_we,
    input  logic [7:0]       clr_bits,
    input  logic             fifo_pop,
    output logic [7:0]       fifo_data,
    output logic [STS_W-1:0] status,
    output logic             irq
);
    samp_cfg_t   cfg;
    logic        run_en;
    logic        smp_tick, smp_lvl;
    logic        flt_tick, flt_lvl;
    logic        enc_push, enc_end;
    run_entry_t  enc_entry;
    logic        fifo_push, fifo_full;
    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] avail_lvl;
    logic        ovf_q, pend_q, avail_q;

    always_comb begin
        cfg       = unpack_cfg(samp_cfg);
        run_en    = en_global && en_rx;
        avail_lvl = int_cfg[8 +: CNT_W];
        fifo_push = enc_push && run_en;
    end

    cir_sampler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .enable   (run_en),
        .slow_sel (cfg.slow),
        .invert   (rx_invert),
        .ir_raw   (ir_in),
        .tick     (smp_tick),
        .level    (smp_lvl)
    );

    cir_glitch_filter u_filter (
        .clk       (clk),
        .rst       (rst),
        .enable    (run_en),
        .tick_in   (smp_tick),
        .level_in  (smp_lvl),
        .min_len   (cfg.min_len),
        .tick_out  (flt_tick),
        .level_out (flt_lvl)
    );

    cir_run_encoder u_encoder (
        .clk       (clk),
        .rst       (rst),
        .enable    (run_en),
        .tick      (flt_tick),
        .level     (flt_lvl),
        .start_len (start_samples(cfg.start_m1, cfg.coarse)),
        .idle_len  (idle_samples(cfg.idle_n)),
        .push      (enc_push),
        .entry     (enc_entry),
        .pkt_end   (enc_end)
    );

    cir_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .din   (enc_entry),
        .pop   (fifo_pop),
        .dout  (fifo_data),
        .count (fill),
        .full  (fifo_full)
    );

    // Sticky status, set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q   <= 1'b0;
            pend_q  <= 1'b0;
            avail_q <= 1'b0;
        end else begin
            if (fifo_push && fifo_full)         ovf_q <= 1'b1;
            else if (clr_we && clr_bits[0])     ovf_q <= 1'b0;
            if (enc_end && run_en)              pend_q <= 1'b1;
            else if (clr_we && clr_bits[1])     pend_q <= 1'b0;
            if (fill > avail_lvl)               avail_q <= 1'b1;
            else if (clr_we && clr_bits[4])     avail_q <= 1'b0;
        end
    end

    always_comb begin
        status              = '0;
        status[0]           = ovf_q;
        status[1]           = pend_q;
        status[4]           = avail_q;
        status[8 +: CNT_W]  = fill;
        irq = (ovf_q & int_cfg[0]) | (pend_q & int_cfg[1]) | (avail_q & int_cfg[4]);
    end

endmodule

// File: rtl/cir_rle_rx_chk.sv
module cir_rle_rx_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7,
    parameter int STS_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             en_global,
    input logic             en_rx,
    input logic [STS_W-1:0] int_cfg,
    input logic             clr_we,
    input logic [7:0]       clr_bits,
    input logic [STS_W-1:0] status,
    input logic             irq
);
    logic [CNT_W-1:0] fill;
    assign fill = status[8 +: CNT_W];

    p_fill_bound_r8: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !(clr_we && clr_bits[0])) |=> status[0]);

    p_pend_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !(clr_we && clr_bits[1])) |=> status[1]);

    p_avail_set_r10: assert property (@(posedge clk) disable iff (rst)
        (fill > int_cfg[8 +: CNT_W]) |=> status[4]);

    p_disabled_no_fill_r1: assert property (@(posedge clk) disable iff (rst)
        !(en_global && en_rx) |=> (fill <= $past(fill)));

    p_irq_masked_r12: assert property (@(posedge clk) disable iff (rst)
        (!int_cfg[0] && !int_cfg[1] && !int_cfg[4]) |-> !irq);

    p_irq_ovf_r12: assert property (@(posedge clk) disable iff (rst)
        (status[0] && int_cfg[0]) |-> irq);

endmodule

bind cir_rle_rx cir_rle_rx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .STS_W(STS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_global (en_global),
    .en_rx     (en_rx),
    .int_cfg   (int_cfg),
    .clr_we    (clr_we),
    .clr_bits  (clr_bits),
    .status    (status),
    .irq       (irq)
);

// File: tb/cir_rle_rx_tb.sv
`timescale 1ns/1ps
module cir_rle_rx_tb;
    localparam int DEPTH = 16;
    localparam int FAST  = 2;
    localparam int SLOW  = 4;
    localparam int CNT_W = 5;
    localparam int STS_W = 13;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, ir_in = 1'b0, en_global = 1'b0, en_rx = 1'b0, rx_invert = 1'b0;
    logic [23:0] samp_cfg = '0;
    logic [STS_W-1:0] int_cfg = '0;
    logic clr_we = 1'b0, fifo_pop = 1'b0;
    logic [7:0] clr_bits = '0;
    logic [7:0] fifo_data;
    logic [STS_W-1:0] status;
    logic irq;

    cir_rle_rx #(.DEPTH(DEPTH), .FAST_DIV(FAST), .SLOW_DIV(SLOW)) u_dut (
        .clk(clk), .rst(rst), .ir_in(ir_in), .en_global(en_global), .en_rx(en_rx),
        .rx_invert(rx_invert), .samp_cfg(samp_cfg), .int_cfg(int_cfg), .clr_we(clr_we),
        .clr_bits(clr_bits), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
        .status(status), .irq(irq)
    );

    int errors = 0, checks = 0, div = FAST;
    logic inv_drv = 1'b0;
    logic [7:0] exp_mem [0:127];
    int exp_n = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_cfg(input logic slow, input int minl, input int idle,
                                           input int thr_m1, input logic coarse);
        return {coarse, 7'(thr_m1), 8'(idle), 6'(minl), 1'b0, slow};
    endfunction

    task automatic add_run(input logic lvl, input int len);
        int n = len;
        while (n >= 128) begin
            if (exp_n < 128) exp_mem[exp_n] = {lvl, 7'd127};
            exp_n++;
            n -= 128;
        end
        if (n > 0) begin
            if (exp_n < 128) exp_mem[exp_n] = {lvl, 7'(n - 1)};
            exp_n++;
        end
    endtask

    task automatic seg(input logic lvl, input int len);
        ir_in = lvl ^ inv_drv;
        repeat (len * div) @(negedge clk);
    endtask

    task automatic play(input logic lvl, input int len);
        seg(lvl, len);
        add_run(lvl, len);
    endtask

    task automatic lead(input int len, input int thr);
        seg(1'b1, len);
        add_run(1'b1, len - thr);
    endtask

    task automatic tail(input int idle);
        seg(1'b0, idle + 16);
        add_run(1'b0, idle);
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        exp_n = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        int n = (exp_n > DEPTH) ? DEPTH : exp_n;
        check({tag, " R8 fill count"}, 32'(status[8 +: CNT_W]), 32'(n));
        for (int i = 0; i < n; i++) begin
            check({tag, " R6/R8 entry"}, 32'(fifo_data), 32'(exp_mem[i]));
            fifo_pop = 1'b1;
            @(negedge clk);
            fifo_pop = 1'b0;
        end
        check({tag, " R8 empty after drain"}, 32'(status[8 +: CNT_W]), 32'd0);
    endtask

    task automatic clr(input logic [7:0] bits);
        clr_we = 1'b1; clr_bits = bits;
        @(negedge clk);
        clr_we = 1'b0; clr_bits = '0;
    endtask

    // Filter 2, start threshold 10, idle 0.
    task automatic basic_packet();
        seg(1'b0, 20);
        lead(30, 10);
        play(1'b0, 12);
        play(1'b1, 5);
        play(1'b0, 20);
        play(1'b1, 200);
        tail(128);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R13 reset state
        check("R13 status after reset", 32'(status), 32'd0);
        check("R13 irq after reset", 32'(irq), 32'd0);

        // R1: receive enable off, then global enable off
        samp_cfg = mk_cfg(1'b0, 2, 0, 9, 1'b0);
        int_cfg  = {5'd3, 8'h13};
        en_global = 1'b1; en_rx = 1'b0;
        basic_packet();
        check("R1 rx disabled status", 32'(status), 32'd0);
        en_global = 1'b0; en_rx = 1'b1;
        basic_packet();
        check("R1 global disabled status", 32'(status), 32'd0);
        check("R1 irq while disabled", 32'(irq), 32'd0);

        // Main packet, fast rate
        do_reset();
        en_global = 1'b1; en_rx = 1'b1;
        basic_packet();
        check("R7/R10 status after packet", 32'(status), 32'h712);
        int_cfg = {5'd3, 8'h02};
        #1 check("R12 irq on packet end", 32'(irq), 32'd1);
        int_cfg = {5'd3, 8'h01};
        #1 check("R12 irq masked", 32'(irq), 32'd0);
        clr(8'h02);
        check("R11 clear packet end", 32'(status), 32'h710);
        clr(8'h10);
        check("R11 avail set wins over clear", 32'(status), 32'h710);
        drain("fast");
        check("R10 avail sticky after drain", 32'(status), 32'h010);
        clr(8'h10);
        check("R11 clear avail", 32'(status), 32'd0);

        // R2 slow rate
        do_reset();
        div = SLOW;
        samp_cfg = mk_cfg(1'b1, 2, 0, 9, 1'b0);
        basic_packet();
        drain("R2 slow rate");
        div = FAST;

        // R3 inversion
        do_reset();
        rx_invert = 1'b1; inv_drv = 1'b1;
        samp_cfg = mk_cfg(1'b0, 2, 0, 9, 1'b0);
        repeat (10) @(negedge clk);
        basic_packet();
        drain("R3 inverted");
        rx_invert = 1'b0; inv_drv = 1'b0; ir_in = 1'b0;

        // R4 glitch filter, F=3
        do_reset();
        samp_cfg = mk_cfg(1'b0, 3, 0, 9, 1'b0);
        seg(1'b0, 10);
        lead(30, 10);
        seg(1'b0, 10); seg(1'b1, 2); seg(1'b0, 10);
        add_run(1'b0, 22);
        seg(1'b1, 8); seg(1'b0, 1); seg(1'b1, 8);
        add_run(1'b1, 17);
        tail(128);
        drain("R4 glitch");

        // R5 coarse start threshold (128 samples)
        do_reset();
        samp_cfg = mk_cfg(1'b0, 1, 0, 0, 1'b1);
        seg(1'b0, 10);
        seg(1'b1, 100);
        seg(1'b0, 20);
        lead(150, 128);
        play(1'b0, 30);
        play(1'b1, 4);
        tail(128);
        drain("R5 coarse start");

        // R5 sweep of fine start thresholds
        for (int t = 0; t < 4; t++) begin
            int thr_m1 = (t == 0) ? 0 : (t == 1) ? 3 : (t == 2) ? 9 : 20;
            do_reset();
            samp_cfg = mk_cfg(1'b0, 1, 0, thr_m1, 1'b0);
            seg(1'b0, 5);
            lead(40, thr_m1 + 1);
            tail(128);
            drain("R5 start sweep");
        end

        // R7 idle count 1: 256 space samples
        do_reset();
        samp_cfg = mk_cfg(1'b0, 1, 1, 4, 1'b0);
        seg(1'b0, 10);
        lead(10, 5);
        seg(1'b0, 200);
        check("R7 no end before idle", 32'(status[1]), 32'd0);
        seg(1'b0, 72);
        add_run(1'b0, 256);
        repeat (8) @(negedge clk);
        check("R7 end after idle", 32'(status[1]), 32'd1);
        drain("R7 idle 256");

        // R9 overflow
        do_reset();
        samp_cfg = mk_cfg(1'b0, 1, 0, 4, 1'b0);
        int_cfg  = {5'd3, 8'h01};
        seg(1'b0, 10);
        lead(8, 5);
        for (int k = 0; k < 20; k++) begin
            play(1'b0, 3);
            play(1'b1, 3);
        end
        tail(128);
        check("R9 status on overflow", 32'(status), 32'h1013);
        check("R12 irq on overflow", 32'(irq), 32'd1);
        drain("R9 kept entries");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule